// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when the backup battery gets measured and keeps the result. A battery test starts each time the main supply becomes nominal. After that, while the supply stays nominal, another test starts after a fixed number of clock cycles. The default interval is a full day at a 100 MHz clock. During a test the block raises a strobe that powers the external battery comparator. The strobe stays up for a settling period. The block then reads the comparator's digital verdict once and stores it in a sticky battery-low flag.

The flag does not move between tests. It keeps its value through battery-backup periods, because the block sits in the always-powered domain. No test runs while the main supply is absent. A status bit records what kind of test last wrote the flag. A power-up test that reads low means the stored data may be suspect. A periodic test that reads low means the battery is near end of life and the data is still intact.

Top module: `batt_low_monitor`

## Requirements
- R1: During and right after reset, `batt_low`, `cmp_en` and `from_powerup` are all 0.
- R2: One clock after `supply_ok` is first sampled high following a period low, `cmp_en` is 1. A reset release with `supply_ok` already high also counts as a power-up.
- R3: A test that is not interrupted holds `cmp_en` high for exactly SETTLE_CYCLES cycles. On the clock that ends the strobe, `batt_low` takes the value of `cmp_low` (1 = battery below threshold) sampled in the last strobe cycle.
- R4: `batt_low` changes only on the clock that ends a strobe. Values on `cmp_low` at any other time have no effect.
- R5: While `supply_ok` stays high, the next test raises `cmp_en` exactly INTERVAL_CYCLES cycles after the clock that completed the previous test.
- R6: While `supply_ok` is low, `cmp_en` is 0 from the next cycle on. A test cut short by the supply dropping leaves `batt_low` and `from_powerup` unchanged.
- R7: `batt_low` keeps its value through any period with `supply_ok` low.
- R8: When a test completes, `from_powerup` becomes 1 if the test was started by a power-up and 0 if it was a periodic test. Between completions it is stable.
- R9: Once set, `batt_low` stays 1 until a completed test samples `cmp_low` = 0.
- R10: The interval count restarts from zero at every power-up test. A partial interval run before a supply loss does not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply is nominal |
| cmp_low | input | 1 | Comparator verdict, 1 = battery below threshold |
| cmp_en | output | 1 | Comparator enable strobe, high for the whole test |
| batt_low | output | 1 | Sticky battery-low flag |
| from_powerup | output | 1 | 1 = the flag was last written by a power-up test |

## Verification
The bench builds the block with an interval of 40 cycles and a settling count of 3. With these values many periodic tests fit in a short run. Every cycle of every interval can be checked for a stray strobe, and comparator noise can be injected during the non-final settling cycles. Seeded random choices interleave periodic tests, supply losses of random length, and tests aborted mid-strobe. This exercises flag retention, sticky clearing, and the interval restart after each power-up.

// File: rtl/batt_low_monitor.sv
module batt_low_monitor #(
  parameter int unsigned CNT_W = 44,
  parameter logic [CNT_W-1:0] INTERVAL_CYCLES = 44'd8640000000000,
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic cmp_low,
  output logic cmp_en,
  output logic batt_low,
  output logic from_powerup
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ILAST = INTERVAL_CYCLES - 1'b1;

  typedef enum logic [1:0] {ST_OFF, ST_CHECK, ST_WAIT} st_t;

  st_t st;
  logic sup_q;
  logic kind_pu;
  logic [SW-1:0] scnt;
  logic [CNT_W-1:0] icnt;

  wire pu_evt = supply_ok & ~sup_q;
  wire settle_done = scnt == SLAST;
  wire interval_done = icnt == ILAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OFF;
      sup_q <= 1'b0;
      kind_pu <= 1'b0;
      scnt <= '0;
      icnt <= '0;
      batt_low <= 1'b0;
      from_powerup <= 1'b0;
    end else begin
      sup_q <= supply_ok;
      if (!supply_ok) begin
        st <= ST_OFF;
      end else if (pu_evt) begin
        st <= ST_CHECK;
        scnt <= '0;
        kind_pu <= 1'b1;
      end else begin
        case (st)
          ST_CHECK: begin
            if (settle_done) begin
              batt_low <= cmp_low;
              from_powerup <= kind_pu;
              st <= ST_WAIT;
              icnt <= '0;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          ST_WAIT: begin
            if (interval_done) begin
              st <= ST_CHECK;
              scnt <= '0;
              kind_pu <= 1'b0;
            end else begin
              icnt <= icnt + 1'b1;
            end
          end
          default: st <= ST_OFF;
        endcase
      end
    end
  end

  assign cmp_en = st == ST_CHECK;
endmodule

// File: rtl/batt_low_monitor_chk.sv
module batt_low_monitor_chk #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic cmp_en,
  input logic batt_low,
  input logic from_powerup
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (cmp_en) run <= run + 1;
    else run <= 0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!cmp_en && !batt_low && !from_powerup));

  a_r2_powerup_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |=> cmp_en);

  a_r3_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmp_en) && $past(supply_ok)) |-> run == SETTLE_CYCLES);

  a_r3_strobe_max: assert property (@(posedge clk) disable iff (!rst_n)
    run <= SETTLE_CYCLES);

  a_r4_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_low != $past(batt_low)) |-> ($past(cmp_en) && !cmp_en));

  a_r6_no_strobe_backup: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !cmp_en);

  a_r8_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_en) |-> $stable(from_powerup));
endmodule

bind batt_low_monitor batt_low_monitor_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .supply_ok(supply_ok),
  .cmp_en(cmp_en),
  .batt_low(batt_low),
  .from_powerup(from_powerup)
);

// File: tb/batt_low_monitor_test.sv
module batt_low_monitor_test;
  localparam int INT = 40;
  localparam int SET = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok;
  logic cmp_low;
  logic cmp_en, batt_low, from_powerup;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_low = 1'b0;
  logic exp_pu = 1'b0;

  always #4 clk = ~clk;

  batt_low_monitor #(
    .CNT_W(44),
    .INTERVAL_CYCLES(44'(INT)),
    .SETTLE_CYCLES(SET)
  ) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cmp_low(cmp_low),
    .cmp_en(cmp_en), .batt_low(batt_low), .from_powerup(from_powerup)
  );

  function automatic logic status_after(input logic started_by_powerup);
    return started_by_powerup;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic noise();
    cmp_low = 1'($urandom);
  endtask

  task automatic run_check(input logic pu, input logic val);
    for (int i = 0; i < SET; i++) begin
      cmp_low = (i == SET - 1) ? val : 1'($urandom);
      if (i < SET - 1) begin
        @(negedge clk);
        check("R3 strobe held", cmp_en, 1'b1);
        check("R4 flag mid-test", batt_low, exp_low);
      end
    end
    @(negedge clk);
    exp_low = val;
    exp_pu = status_after(pu);
    check("R3 strobe ends", cmp_en, 1'b0);
    check("R3 R9 flag result", batt_low, exp_low);
    check("R8 status", from_powerup, exp_pu);
  endtask

  task automatic power_up(input logic val);
    supply_ok = 1'b1;
    noise();
    @(negedge clk);
    check("R2 strobe on power-up", cmp_en, 1'b1);
    run_check(1'b1, val);
  endtask

  task automatic wait_periodic(input logic val);
    for (int i = 0; i < INT - 1; i++) begin
      @(negedge clk);
      noise();
      check("R5 R10 no early strobe", cmp_en, 1'b0);
      check("R4 flag held", batt_low, exp_low);
    end
    @(negedge clk);
    check("R5 periodic strobe", cmp_en, 1'b1);
    run_check(1'b0, val);
  endtask

  task automatic backup(input int n);
    supply_ok = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      noise();
      check("R6 no strobe in backup", cmp_en, 1'b0);
      check("R7 flag retained", batt_low, exp_low);
      check("R8 status retained", from_powerup, exp_pu);
    end
  endtask

  task automatic abort_check();
    supply_ok = 1'b1;
    @(negedge clk);
    check("R2 strobe before abort", cmp_en, 1'b1);
    cmp_low = ~exp_low;
    supply_ok = 1'b0;
    @(negedge clk);
    check("R6 abort strobe off", cmp_en, 1'b0);
    check("R6 abort flag kept", batt_low, exp_low);
    check("R6 abort status kept", from_powerup, exp_pu);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    supply_ok = 1'b0;
    cmp_low = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset flag", batt_low, 1'b0);
    check("R1 reset strobe", cmp_en, 1'b0);
    check("R1 reset status", from_powerup, 1'b0);
    rst_n = 1'b1;
    backup(5);
    power_up(1'b1);
    wait_periodic(1'b1);
    wait_periodic(1'b0);
    wait_periodic(1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      noise();
      check("R4 flag held", batt_low, exp_low);
    end
    backup(20);
    power_up(1'b1);
    wait_periodic(1'b1);
    backup(3);
    abort_check();
    backup(4);
    power_up(1'b0);
    for (int k = 0; k < 10; k++) begin
      case ($urandom % 3)
        0: wait_periodic(1'($urandom));
        1: begin
          for (int j = 0; j < int'($urandom % INT); j++) begin
            @(negedge clk);
            noise();
            check("R4 flag held", batt_low, exp_low);
          end
          backup(3 + int'($urandom % 30));
          power_up(1'($urandom));
        end
        default: begin
          backup(2);
          abort_check();
          backup(2 + int'($urandom % 5));
          power_up(1'($urandom));
        end
      endcase
    end
    wait_periodic(1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule